// File: doc/BRIEF.md
# Core Voltage Step Controller

This block turns a supply voltage request, given in millivolts, into a 5-bit regulator target code. It writes that code into three target fields of a regulator control word in a single write. It then holds a busy signal while the supply settles. The settle time is counted on a 1 µs tick input, so it does not depend on the system clock frequency. A voltage increase waits three microseconds for each code step. A decrease needs no wait. The first change after reset always waits a long, fixed time, because the rails may start out unequal.

A power manager raises `req_valid` for one cycle with `req_mv` while `busy` is low. The block accepts the request on that edge and sets `busy`. One evaluation cycle later it either writes the new word, with `ctl_we` high for one cycle, or finds nothing to do. When any settle time has run out, it drops `busy` and pulses `done`. `cur_mv` reports the voltage that the last written code stands for.

Top module: `vstep_ctrl`

## Requirements
- R1: A request below 725 mV gives target code 0.
- R2: A request above 1450 mV gives target code 31.
- R3: A request from 725 to 1450 mV gives code (mV - 700) / 25, with truncating division; for example 749 gives 1 and 1449 gives 29.
- R4: The code sits in all three target fields of `ctl_word`, at bits [4:0], [12:8] and [20:16]. Every other bit keeps its reset value.
- R5: `ctl_word` changes only in a cycle where `ctl_we` is high, and `ctl_we` is high for one cycle per write.
- R6: After the first write, a request whose code equals the current code gives no write and no wait. `done` pulses in the cycle after the evaluation cycle.
- R7: After the first write, a higher code holds `busy` for exactly 3 ticks per code step of the increase, counting from the write.
- R8: After the first write, a lower code is written with no wait. `done` rises in the same cycle as `ctl_we`.
- R9: The first request after reset always writes, whatever its code. It waits 84 ticks.
- R10: `cur_mv` equals code × 25 + 700 for the last written code, and is 700 after reset.
- R11: A request that arrives while `busy` is high is dropped. It causes no write and leaves `cur_mv` unchanged.
- R12: `done` is a one-cycle pulse and `busy` falls in that same cycle. `busy` is high from the cycle after an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_mv | input | 12 | Requested voltage in millivolts |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| ctl_word | output | 32 | Regulator control word |
| ctl_we | output | 1 | Write strobe for `ctl_word` |
| busy | output | 1 | Request in progress or supply settling |
| done | output | 1 | One-cycle completion pulse |
| cur_mv | output | 12 | Voltage of the last written code, in millivolts |

## Verification
The hardest state to reach is the long fixed first-change wait. It occurs once per reset, so the bench asserts reset again partway through and repeats a first request whose code equals the reset code. Dropped requests only matter while a settle is running. The bench therefore injects a second strobe a few cycles into an upward wait and then watches for stray writes afterwards. Sweeps in both directions then reach every code, including the clamp edges and the truncation points.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVAL   = 2'd1,
    ST_SETTLE = 2'd2
  } vstep_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vstep_quant.sv
module vstep_quant #(
  parameter int MV_W    = 12,
  parameter int CODE_W  = 5,
  parameter int BASE_MV = 700,
  parameter int STEP_MV = 25,
  parameter int LO_MV   = 725,
  parameter int HI_MV   = 1450
) (
  input  logic [MV_W-1:0]   mv,
  output logic [CODE_W-1:0] code
);
  int unsigned mv_i;

  always_comb begin
    mv_i = int'(mv);
    if (mv_i < LO_MV)
      code = '0;
    else if (mv_i > HI_MV)
      code = '1;
    else
      code = CODE_W'((mv_i - BASE_MV) / STEP_MV);
  end
endmodule

// File: rtl/vstep_delay_calc.sv
module vstep_delay_calc #(
  parameter int CODE_W      = 5,
  parameter int WAIT_W      = 7,
  parameter int STEP_US     = 3,
  parameter int FIRST_STEPS = 28
) (
  input  logic              first_pending,
  input  logic [CODE_W-1:0] new_code,
  input  logic [CODE_W-1:0] old_code,
  output logic              write_needed,
  output logic [WAIT_W-1:0] wait_us
);
  int unsigned rise;

  always_comb begin
    rise = 0;
    if (new_code > old_code)
      rise = int'(new_code) - int'(old_code);
    write_needed = first_pending || (new_code != old_code);
    if (first_pending)
      wait_us = WAIT_W'(FIRST_STEPS * STEP_US);
    else
      wait_us = WAIT_W'(rise * STEP_US);
  end
endmodule

// File: rtl/vstep_settle_timer.sv
module vstep_settle_timer #(
  parameter int WAIT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              tick,
  output logic              expire
);
  logic [WAIT_W-1:0] remain;

  assign expire = tick && (remain == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (tick && remain != '0)
      remain <= remain - WAIT_W'(1);
  end
endmodule

// File: rtl/vstep_word_pack.sv
module vstep_word_pack #(
  parameter int WORD_W                  = 32,
  parameter int CODE_W                  = 5,
  parameter int NUM_FIELDS              = 3,
  parameter logic [NUM_FIELDS*8-1:0] FIELD_LSBS = {8'd16, 8'd8, 8'd0}
) (
  input  logic [WORD_W-1:0] base_word,
  input  logic [CODE_W-1:0] code,
  output logic [WORD_W-1:0] packed_word
);
  logic [WORD_W-1:0] field_mask [NUM_FIELDS];
  logic [WORD_W-1:0] field_val  [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int LSB = int'(FIELD_LSBS[g*8 +: 8]);
    assign field_mask[g] = {{(WORD_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << LSB;
    assign field_val[g]  = {{(WORD_W-CODE_W){1'b0}}, code} << LSB;
  end

  always_comb begin
    packed_word = base_word;
    for (int i = 0; i < NUM_FIELDS; i++)
      packed_word = (packed_word & ~field_mask[i]) | field_val[i];
  end
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl #(
  parameter int MV_W        = 12,
  parameter int CODE_W      = 5,
  parameter int WORD_W      = 32,
  parameter int NUM_FIELDS  = 3,
  parameter logic [NUM_FIELDS*8-1:0] FIELD_LSBS = {8'd16, 8'd8, 8'd0},
  parameter logic [WORD_W-1:0] INIT_WORD = 32'hA5E0_40C0,
  parameter int BASE_MV     = 700,
  parameter int STEP_MV     = 25,
  parameter int LO_MV       = 725,
  parameter int HI_MV       = 1450,
  parameter int STEP_US     = 3,
  parameter int FIRST_STEPS = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MV_W-1:0]   req_mv,
  input  logic              tick_1us,
  output logic [WORD_W-1:0] ctl_word,
  output logic              ctl_we,
  output logic              busy,
  output logic              done,
  output logic [MV_W-1:0]   cur_mv
);
  import vstep_pkg::*;

  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int MAX_WAIT = max_int(FIRST_STEPS, MAX_CODE) * STEP_US;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

  vstep_state_e      state;
  logic [CODE_W-1:0] req_code_c;
  logic [CODE_W-1:0] req_code_q;
  logic [CODE_W-1:0] cur_code;
  logic              first_pending;
  logic              write_needed;
  logic [WAIT_W-1:0] wait_us;
  logic [WORD_W-1:0] packed_word;
  logic              tmr_load;
  logic              tmr_expire;

  vstep_quant #(
    .MV_W(MV_W), .CODE_W(CODE_W), .BASE_MV(BASE_MV),
    .STEP_MV(STEP_MV), .LO_MV(LO_MV), .HI_MV(HI_MV)
  ) u_quant (
    .mv(req_mv), .code(req_code_c)
  );

  vstep_delay_calc #(
    .CODE_W(CODE_W), .WAIT_W(WAIT_W),
    .STEP_US(STEP_US), .FIRST_STEPS(FIRST_STEPS)
  ) u_delay (
    .first_pending(first_pending), .new_code(req_code_q),
    .old_code(cur_code), .write_needed(write_needed), .wait_us(wait_us)
  );

  vstep_word_pack #(
    .WORD_W(WORD_W), .CODE_W(CODE_W),
    .NUM_FIELDS(NUM_FIELDS), .FIELD_LSBS(FIELD_LSBS)
  ) u_pack (
    .base_word(ctl_word), .code(req_code_q), .packed_word(packed_word)
  );

  assign tmr_load = (state == ST_EVAL) && write_needed && (wait_us != '0);

  vstep_settle_timer #(
    .WAIT_W(WAIT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(wait_us),
    .tick(tick_1us), .expire(tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      req_code_q    <= '0;
      cur_code      <= '0;
      first_pending <= 1'b1;
      ctl_word      <= INIT_WORD;
      ctl_we        <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      cur_mv        <= MV_W'(BASE_MV);
    end else begin
      ctl_we <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_code_q <= req_code_c;
            busy       <= 1'b1;
            state      <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (write_needed) begin
            ctl_word      <= packed_word;
            ctl_we        <= 1'b1;
            cur_code      <= req_code_q;
            cur_mv        <= MV_W'(BASE_MV + int'(req_code_q) * STEP_MV);
            first_pending <= 1'b0;
          end
          if (tmr_load) begin
            state <= ST_SETTLE;
          end else begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_expire) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vstep_ctrl_chk.sv
module vstep_ctrl_chk #(
  parameter int MV_W        = 12,
  parameter int CODE_W      = 5,
  parameter int WORD_W      = 32,
  parameter int NUM_FIELDS  = 3,
  parameter logic [NUM_FIELDS*8-1:0] FIELD_LSBS = {8'd16, 8'd8, 8'd0},
  parameter logic [WORD_W-1:0] INIT_WORD = 32'hA5E0_40C0,
  parameter int BASE_MV     = 700,
  parameter int STEP_MV     = 25
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] ctl_word,
  input logic              ctl_we,
  input logic              busy,
  input logic              done,
  input logic [MV_W-1:0]   cur_mv
);
  function automatic logic [WORD_W-1:0] all_fields();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      m = m | ({{(WORD_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << int'(FIELD_LSBS[i*8 +: 8]));
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FMASK = all_fields();
  localparam int LSB0 = int'(FIELD_LSBS[7:0]);

  logic [CODE_W-1:0] f0;
  assign f0 = ctl_word[LSB0 +: CODE_W];

  AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (ctl_word & ~FMASK) == (INIT_WORD & ~FMASK)); // R4

  for (genvar g = 1; g < NUM_FIELDS; g++) begin : g_eq
    localparam int LSB = int'(FIELD_LSBS[g*8 +: 8]);
    AST_FIELDS_MATCH: assert property (@(posedge clk) disable iff (rst)
      ctl_we |-> (ctl_word[LSB +: CODE_W] == f0)); // R4
  end

  AST_WORD_ONLY_ON_WE: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |-> $stable(ctl_word)); // R5

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> !ctl_we); // R5

  AST_MV_FROM_CODE: assert property (@(posedge clk) disable iff (rst)
    ctl_we |-> (int'(cur_mv) == BASE_MV + int'(f0) * STEP_MV)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R12

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R12
endmodule

bind vstep_ctrl vstep_ctrl_chk #(
  .MV_W(MV_W), .CODE_W(CODE_W), .WORD_W(WORD_W), .NUM_FIELDS(NUM_FIELDS),
  .FIELD_LSBS(FIELD_LSBS), .INIT_WORD(INIT_WORD),
  .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
) u_chk (
  .clk(clk), .rst(rst), .ctl_word(ctl_word), .ctl_we(ctl_we),
  .busy(busy), .done(done), .cur_mv(cur_mv)
);

// File: tb/vstep_ctrl_tb.sv
module vstep_ctrl_tb;
  localparam logic [31:0] INIT  = 32'hA5E0_40C0;
  localparam logic [31:0] FMASK = 32'h001F_1F1F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_mv = '0;
  logic        tick_1us = 1'b0;
  logic [31:0] ctl_word;
  logic        ctl_we;
  logic        busy;
  logic        done;
  logic [11:0] cur_mv;

  int errors = 0;
  int checks = 0;
  int exp_code = 0;
  bit first = 1'b1;
  int tick_div = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
    tick_1us <= (tick_div == 2);
  end

  vstep_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mv(req_mv),
    .tick_1us(tick_1us), .ctl_word(ctl_word), .ctl_we(ctl_we),
    .busy(busy), .done(done), .cur_mv(cur_mv)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int quant(input int mv);
    if (mv < 725) return 0;
    if (mv > 1450) return 31;
    return (mv - 700) / 25;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    first = 1'b1;
    exp_code = 0;
    @(negedge clk); #1;
    check(busy == 1'b0, "R12", "reset busy", int'(busy), 0);
    check(done == 1'b0 && ctl_we == 1'b0, "R5", "reset strobes", int'(done | ctl_we), 0);
    check(ctl_word == INIT, "R4", "reset word", int'(ctl_word), int'(INIT));
    check(cur_mv == 12'd700, "R10", "reset mv", int'(cur_mv), 700);
  endtask

  task automatic run_req(input int mv, input string tag, input int inject_mv);
    int  code, exp_wait, ticks, cyc, we_cnt, done_cyc, we_cyc;
    bit  exp_write;
    code = quant(mv);
    exp_write = first || (code != exp_code);
    if (first) exp_wait = 84;
    else if (code > exp_code) exp_wait = (code - exp_code) * 3;
    else exp_wait = 0;
    @(negedge clk); #1;
    req_mv = 12'(mv);
    req_valid = 1'b1;
    ticks = 0; we_cnt = 0; done_cyc = -1; we_cyc = -1;
    for (cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk); #1;
      req_valid = 1'b0;
      if (cyc == 0)
        check(busy == 1'b1, "R12", {tag, " busy after accept"}, int'(busy), 1);
      if (inject_mv >= 0 && cyc == 4) begin
        req_mv = 12'(inject_mv);
        req_valid = 1'b1;
      end
      if (ctl_we) begin
        we_cnt++;
        we_cyc = cyc;
      end
      if (we_cnt > 0 && busy && tick_1us) ticks++;
      if (done) begin
        done_cyc = cyc;
        break;
      end
    end
    req_valid = 1'b0;
    check(done_cyc >= 0, "R12", {tag, " done seen"}, done_cyc, 0);
    check(we_cnt == int'(exp_write), exp_write ? "R5" : "R6",
          {tag, " write count"}, we_cnt, int'(exp_write));
    if (!exp_write)
      check(done_cyc == 1, "R6", {tag, " no-op done cycle"}, done_cyc, 1);
    else if (exp_wait == 0)
      check(we_cyc == done_cyc, "R8", {tag, " down done with write"}, done_cyc, we_cyc);
    check(ticks == exp_wait, first ? "R9" : (exp_wait > 0 ? "R7" : "R8"),
          {tag, " settle ticks"}, ticks, exp_wait);
    if (mv < 725)
      check(ctl_word[4:0] == 5'(code), "R1", {tag, " low clamp"}, int'(ctl_word[4:0]), code);
    else if (mv > 1450)
      check(ctl_word[4:0] == 5'(code), "R2", {tag, " high clamp"}, int'(ctl_word[4:0]), code);
    else
      check(ctl_word[4:0] == 5'(code), "R3", {tag, " code"}, int'(ctl_word[4:0]), code);
    check(ctl_word[12:8] == 5'(code) && ctl_word[20:16] == 5'(code), "R4",
          {tag, " fields"}, int'(ctl_word[20:16]), code);
    check((ctl_word & ~FMASK) == (INIT & ~FMASK), "R4", {tag, " other bits"},
          int'(ctl_word & ~FMASK), int'(INIT & ~FMASK));
    check(int'(cur_mv) == code * 25 + 700, "R10", {tag, " mv"}, int'(cur_mv), code * 25 + 700);
    we_cnt = 0;
    repeat (10) begin
      @(negedge clk); #1;
      if (ctl_we) we_cnt++;
    end
    check(we_cnt == 0, inject_mv >= 0 ? "R11" : "R5", {tag, " no stray write"}, we_cnt, 0);
    if (inject_mv >= 0)
      check(int'(cur_mv) == code * 25 + 700, "R11", {tag, " mv after drop"},
            int'(cur_mv), code * 25 + 700);
    exp_code = code;
    first = 1'b0;
  endtask

  initial begin
    do_reset();
    run_req(600, "first same code", -1);
    for (int mv = 600; mv <= 1500; mv += 9) run_req(mv, "up sweep", -1);
    for (int mv = 1500; mv >= 600; mv -= 11) run_req(mv, "down sweep", -1);
    run_req(724, "edge724", -1);
    run_req(725, "edge725", -1);
    run_req(726, "edge726", -1);
    run_req(749, "edge749", -1);
    run_req(750, "edge750", -1);
    run_req(750, "repeat750", -1);
    run_req(1449, "edge1449", -1);
    run_req(1450, "edge1450", -1);
    run_req(1451, "edge1451", -1);
    run_req(4095, "max", -1);
    run_req(4000, "repeat max", -1);
    run_req(0, "zero", -1);
    run_req(1200, "inject during up", 800);
    run_req(1000, "down to 1000", -1);
    do_reset();
    run_req(1000, "first up", -1);
    run_req(1000, "first repeat", -1);
    do_reset();
    run_req(0, "first at zero", -1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule